// File: doc/BRIEF.md
# Calendar Update Engine with Alarm

This block keeps a time-of-day and calendar (seconds, minutes, hours, day of week, date, month, two-digit year) in an internal binary copy. It advances that copy once per second, driven by a sub-second tick from a prescaler. After each advance it copies the result into an eleven-byte buffer that a host can read, with one exception: while the transfer-inhibit input is high, the copy is skipped. Just before each advance an update-in-progress flag rises. This gives polling software a warning window in which the time bytes are about to change. The host sees the time bytes either in binary or in packed BCD, and the hour either in 24-hour form or in 12-hour form with a PM flag.

The host sets the time by raising transfer-inhibit and writing time bytes. It then drops transfer-inhibit. Only the bytes written during the inhibit window are taken into the internal copy, and this happens before the next advance. An alarm compares seconds, minutes, hours and date against four alarm bytes, each of which can be marked don't-care. This allows alarms once per second, minute, hour, day or month. An optional daylight-saving rule moves the clock forward and back on fixed Sundays.

Top module: `rtc_update_engine`

## Requirements
- R1: With `osc_run_i` high, one advance happens every TICKS_PER_SEC ticks. `upd_done_o` is a single-cycle pulse in the cycle after the advance. `uip_o` rises on the tick that leaves UIP_LEAD_TICKS ticks before the rollover tick, stays high through the done cycle and falls after it. With the tick held high, that is LEAD+2 of every TICKS_PER_SEC cycles.
- R2: While `inhibit_i` is high, the buffer is not written by updates and `uip_o` reads 0, but the internal time keeps advancing. After release, the next done cycle publishes the advanced time.
- R3: When `inhibit_i` falls, each time byte written during the inhibit window replaces its internal field before the next advance. Fields that were not written keep counting.
- R4: In binary format (`bin_fmt_i`=1), each field holds its plain value. Time rolls over as follows:
  - seconds 0..59 and minutes 0..59;
  - hours 0..23;
  - day of week 1..7, where 1 is Sunday, moving 7 to 1 at midnight;
  - date 1 up to the month length, with 30 days for months 4, 6, 9 and 11, 29 for February when year mod 4 is 0, 28 for other Februaries and 31 for the rest;
  - month 1..12;
  - year 0..99, with 99 wrapping to 0.
- R5: In BCD format (`bin_fmt_i`=0), each byte holds tens in bits 7:4 and units in bits 3:0. Host writes are decoded the same way.
- R6: With `hr24_i`=0, the hour byte carries 1..12 in bits 6:0 and sets bit 7 for PM. Midnight reads as 12 without bit 7, and noon reads as 12 with bit 7.
- R7: While `osc_run_i` is low, no update and no `uip_o` occur. After it rises, the first `upd_done_o` comes TICKS_PER_SEC/2 ticks plus one cycle later.
- R8: `alarm_o` pulses only with `upd_done_o`, and only when every non-don't-care alarm byte equals the new time byte. A seconds, minutes or hours alarm byte with bits 7:6 = 11 is don't-care.
- R9: A date alarm byte of 0 is don't-care. Any other value must equal the date byte.
- R10: With `dst_en_i`=1, on a Sunday in month 4 with date 1..7, the advance from 01:59:59 goes to 03:00:00.
- R11: With `dst_en_i`=1, on a Sunday in month 10 with date 25..31, the first advance from 01:59:59 goes to 01:00:00. A later pass on the same day advances normally, and the once-only flag clears at midnight.
- R12: Buffer addresses are 0 sec, 1 min, 2 hour, 3 day of week, 4 date, 5 month, 6 year, 7 sec alarm, 8 min alarm, 9 hour alarm and 10 date alarm. Addresses 11..15 read 0 and ignore writes. All bytes reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sub-second tick strobe, TICKS_PER_SEC per second |
| osc_run_i | input | 1 | Divider run enable |
| bin_fmt_i | input | 1 | 1 binary, 0 BCD |
| hr24_i | input | 1 | 1 24-hour, 0 12-hour |
| dst_en_i | input | 1 | Daylight-saving rule enable |
| inhibit_i | input | 1 | Transfer inhibit |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 4 | Host write address |
| wr_data_i | input | 8 | Host write data |
| rd_addr_i | input | 4 | Host read address |
| rd_data_o | output | 8 | Host read data (combinational) |
| uip_o | output | 1 | Update in progress |
| upd_done_o | output | 1 | Update-ended pulse |
| alarm_o | output | 1 | Alarm pulse |

## Verification
The bench sweeps the last day of every month and the February of eight consecutive years. A wrong month-length table or leap rule then shows up as a missed or premature date rollover. Every hour is stepped in 12-hour BCD mode, so a design that mishandles midnight or noon would publish hour 0 or drop the PM bit. Inhibit tests look for two faults: a buffer that keeps changing while frozen, and a partial write that wipes the fields the host never touched. The daylight-saving cases include a second pass through 01:59 on the fall-back Sunday, which a design without the once-only flag would loop back again.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W      = 4;
  localparam int unsigned NUM_REGS    = 11;
  localparam int unsigned TIME_FIELDS = 7;
  localparam int unsigned A_HR        = 2;
  localparam int unsigned A_SALM      = 7;
  localparam int unsigned A_MALM      = 8;
  localparam int unsigned A_HALM      = 9;
  localparam int unsigned A_DALM      = 10;

  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hr;
    logic [2:0] dow;
    logic [4:0] date;
    logic [3:0] mon;
    logic [6:0] yr;
  } rtc_time_t;

  function automatic logic [7:0] enc_byte(input logic [6:0] v, input logic bin);
    logic [6:0] tens, ones;
    tens = v / 7'd10;
    ones = v - tens * 7'd10;
    return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [6:0] dec_byte(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : ({3'd0, b[7:4]} * 7'd10 + {3'd0, b[3:0]});
  endfunction

  function automatic logic [7:0] enc_hour(input logic [4:0] h, input logic bin,
                                          input logic h24);
    logic [4:0] h12;
    logic [7:0] e;
    if (h24) return enc_byte({2'd0, h}, bin);
    if (h == 5'd0)       h12 = 5'd12;
    else if (h > 5'd12)  h12 = h - 5'd12;
    else                 h12 = h;
    e = enc_byte({2'd0, h12}, bin);
    return {(h >= 5'd12), e[6:0]};
  endfunction

  function automatic logic [4:0] dec_hour(input logic [7:0] b, input logic bin,
                                          input logic h24);
    logic [6:0] v;
    if (h24) begin
      v = dec_byte(b, bin);
      return v[4:0];
    end
    v = dec_byte({1'b0, b[6:0]}, bin);
    return ((v[4:0] == 5'd12) ? 5'd0 : v[4:0]) + (b[7] ? 5'd12 : 5'd0);
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [6:0] yr);
    case (mon)
      4'd2:                    return (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                 return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer #(
  parameter int unsigned TICKS_PER_SEC  = 4096,
  parameter int unsigned UIP_LEAD_TICKS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic step_o,
  output logic done_o,
  output logic uip_o
);
  localparam int unsigned CW     = $clog2(TICKS_PER_SEC);
  localparam int unsigned HALF   = TICKS_PER_SEC / 2;
  localparam int unsigned LAST   = TICKS_PER_SEC - 1;
  localparam int unsigned UIP_AT = TICKS_PER_SEC - UIP_LEAD_TICKS - 1;

  logic [CW-1:0] cnt_q;
  logic          step_q, done_q, uip_q;
  logic          wrap;

  assign wrap = tick_i && (cnt_q == CW'(LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CW'(HALF);
      step_q <= 1'b0;
      done_q <= 1'b0;
      uip_q  <= 1'b0;
    end else if (!run_i) begin
      // held mid-second so the first advance lands half a second after start
      cnt_q  <= CW'(HALF);
      step_q <= 1'b0;
      done_q <= 1'b0;
      uip_q  <= 1'b0;
    end else begin
      step_q <= wrap;
      done_q <= step_q;
      if (tick_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (tick_i && cnt_q == CW'(UIP_AT)) uip_q <= 1'b1;
      else if (done_q)                    uip_q <= 1'b0;
    end
  end

  assign step_o = step_q;
  assign done_o = done_q;
  assign uip_o  = uip_q;
endmodule

// File: rtl/rtc_time_adv.sv
module rtc_time_adv
  import rtc_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   step_i,
  input  logic                   load_i,
  input  logic [TIME_FIELDS-1:0] load_mask_i,
  input  rtc_time_t              load_val_i,
  input  logic                   dst_en_i,
  output rtc_time_t              time_o
);
  rtc_time_t time_q, base, nxt;
  logic      fall_done_q;
  logic      at_159, spring, fall, eod;

  always_comb begin
    base = time_q;
    if (load_i) begin
      if (load_mask_i[0]) base.sec  = load_val_i.sec;
      if (load_mask_i[1]) base.min  = load_val_i.min;
      if (load_mask_i[2]) base.hr   = load_val_i.hr;
      if (load_mask_i[3]) base.dow  = load_val_i.dow;
      if (load_mask_i[4]) base.date = load_val_i.date;
      if (load_mask_i[5]) base.mon  = load_val_i.mon;
      if (load_mask_i[6]) base.yr   = load_val_i.yr;
    end
    at_159 = base.hr == 5'd1 && base.min == 6'd59 && base.sec == 6'd59;
    spring = dst_en_i && at_159 && base.mon == 4'd4 && base.dow == 3'd1 &&
             base.date <= 5'd7;
    fall   = dst_en_i && at_159 && base.mon == 4'd10 && base.dow == 3'd1 &&
             base.date >= 5'd25 && !fall_done_q;
    eod    = base.hr == 5'd23 && base.min == 6'd59 && base.sec == 6'd59;

    nxt = base;
    if (spring) begin
      nxt.hr = 5'd3; nxt.min = '0; nxt.sec = '0;
    end else if (fall) begin
      nxt.hr = 5'd1; nxt.min = '0; nxt.sec = '0;
    end else if (base.sec != 6'd59) begin
      nxt.sec = base.sec + 6'd1;
    end else begin
      nxt.sec = '0;
      if (base.min != 6'd59) nxt.min = base.min + 6'd1;
      else begin
        nxt.min = '0;
        if (base.hr != 5'd23) nxt.hr = base.hr + 5'd1;
        else begin
          nxt.hr  = '0;
          nxt.dow = (base.dow == 3'd7) ? 3'd1 : base.dow + 3'd1;
          if (base.date >= month_days(base.mon, base.yr)) begin
            nxt.date = 5'd1;
            if (base.mon == 4'd12) begin
              nxt.mon = 4'd1;
              nxt.yr  = (base.yr == 7'd99) ? 7'd0 : base.yr + 7'd1;
            end else nxt.mon = base.mon + 4'd1;
          end else nxt.date = base.date + 5'd1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q      <= '{sec: '0, min: '0, hr: '0, dow: 3'd1, date: 5'd1, mon: 4'd1, yr: '0};
      fall_done_q <= 1'b0;
    end else begin
      if (step_i)      time_q <= nxt;
      else if (load_i) time_q <= base;
      if (step_i && fall)     fall_done_q <= 1'b1;
      else if (step_i && eod) fall_done_q <= 1'b0;
    end
  end

  assign time_o = time_q;
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp (
  input  logic [2:0][7:0] now_hms_i,
  input  logic [2:0][7:0] alm_hms_i,
  input  logic [7:0]      now_date_i,
  input  logic [7:0]      alm_date_i,
  output logic            match_o
);
  logic [2:0] hit;

  for (genvar i = 0; i < 3; i++) begin : g_slot
    assign hit[i] = (alm_hms_i[i][7:6] == 2'b11) || (alm_hms_i[i] == now_hms_i[i]);
  end

  assign match_o = (&hit) && ((alm_date_i == 8'h00) || (alm_date_i == now_date_i));
endmodule

// File: rtl/rtc_update_engine.sv
module rtc_update_engine
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC  = 4096,
  parameter int unsigned UIP_LEAD_TICKS = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              osc_run_i,
  input  logic              bin_fmt_i,
  input  logic              hr24_i,
  input  logic              dst_en_i,
  input  logic              inhibit_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              uip_o,
  output logic              upd_done_o,
  output logic              alarm_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);
  localparam logic [ADDR_W-1:0] LAST_TIME = ADDR_W'(TIME_FIELDS - 1);

  logic                   step, done, uip_raw, match;
  logic                   inh_q, load;
  logic [TIME_FIELDS-1:0] dirty_q;
  logic [7:0]             buf_q [NUM_REGS];
  logic [6:0]             fld [TIME_FIELDS];
  logic [7:0]             fmt_time [TIME_FIELDS];
  rtc_time_t              cur, load_val;

  rtc_tick_timer #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .UIP_LEAD_TICKS(UIP_LEAD_TICKS)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (osc_run_i),
    .tick_i(tick_i),
    .step_o(step),
    .done_o(done),
    .uip_o (uip_raw)
  );

  assign load = inh_q && !inhibit_i;

  always_comb begin
    logic [6:0] tmp;
    tmp = dec_byte(buf_q[0], bin_fmt_i);  load_val.sec  = tmp[5:0];
    tmp = dec_byte(buf_q[1], bin_fmt_i);  load_val.min  = tmp[5:0];
    load_val.hr = dec_hour(buf_q[A_HR], bin_fmt_i, hr24_i);
    tmp = dec_byte(buf_q[3], bin_fmt_i);  load_val.dow  = tmp[2:0];
    tmp = dec_byte(buf_q[4], bin_fmt_i);  load_val.date = tmp[4:0];
    tmp = dec_byte(buf_q[5], bin_fmt_i);  load_val.mon  = tmp[3:0];
    tmp = dec_byte(buf_q[6], bin_fmt_i);  load_val.yr   = tmp;
  end

  rtc_time_adv u_adv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .load_i     (load),
    .load_mask_i(dirty_q),
    .load_val_i (load_val),
    .dst_en_i   (dst_en_i),
    .time_o     (cur)
  );

  assign fld[0] = {1'b0, cur.sec};
  assign fld[1] = {1'b0, cur.min};
  assign fld[2] = {2'b0, cur.hr};
  assign fld[3] = {4'b0, cur.dow};
  assign fld[4] = {2'b0, cur.date};
  assign fld[5] = {3'b0, cur.mon};
  assign fld[6] = cur.yr;

  for (genvar i = 0; i < TIME_FIELDS; i++) begin : g_fmt
    if (i == A_HR) begin : g_hr
      assign fmt_time[i] = enc_hour(fld[i][4:0], bin_fmt_i, hr24_i);
    end else begin : g_plain
      assign fmt_time[i] = enc_byte(fld[i], bin_fmt_i);
    end
  end

  rtc_alarm_cmp u_alarm (
    .now_hms_i ({fmt_time[A_HR], fmt_time[1], fmt_time[0]}),
    .alm_hms_i ({buf_q[A_HALM], buf_q[A_MALM], buf_q[A_SALM]}),
    .now_date_i(fmt_time[4]),
    .alm_date_i(buf_q[A_DALM]),
    .match_o   (match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inh_q   <= 1'b0;
      dirty_q <= '0;
      for (int i = 0; i < NUM_REGS; i++) buf_q[i] <= '0;
    end else begin
      inh_q <= inhibit_i;
      if (load) dirty_q <= '0;
      else if (wr_en_i && inhibit_i && wr_addr_i <= LAST_TIME)
        dirty_q[wr_addr_i[2:0]] <= 1'b1;
      if (done && !inhibit_i)
        for (int i = 0; i < TIME_FIELDS; i++) buf_q[i] <= fmt_time[i];
      if (wr_en_i && wr_addr_i <= LAST_ADDR) buf_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o  = (rd_addr_i <= LAST_ADDR) ? buf_q[rd_addr_i] : 8'h00;
  assign uip_o      = uip_raw && !inhibit_i;
  assign upd_done_o = done;
  assign alarm_o    = done && match;
endmodule

// File: rtl/rtc_update_engine_chk.sv
module rtc_update_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       osc_run_i,
  input logic       inhibit_i,
  input logic       wr_en_i,
  input logic [3:0] rd_addr_i,
  input logic [7:0] rd_data_o,
  input logic       uip_o,
  input logic       upd_done_o,
  input logic       alarm_o
);
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_o |=> !upd_done_o); // R1

  AST_UIP_SPANS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_done_o && !inhibit_i) |-> uip_o); // R1

  AST_FROZEN_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit_i && $past(inhibit_i) && !$past(wr_en_i) && $stable(rd_addr_i))
      |-> $stable(rd_data_o)); // R2

  AST_IDLE_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_run_i && !$past(osc_run_i)) |-> (!upd_done_o && !uip_o)); // R7

  AST_ALARM_IN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> upd_done_o); // R8
endmodule

bind rtc_update_engine rtc_update_engine_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .osc_run_i (osc_run_i),
  .inhibit_i (inhibit_i),
  .wr_en_i   (wr_en_i),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o),
  .uip_o     (uip_o),
  .upd_done_o(upd_done_o),
  .alarm_o   (alarm_o)
);

// File: tb/rtc_update_engine_tb.sv
`timescale 1ns/1ps
module rtc_update_engine_tb;
  localparam int TPS  = 8;
  localparam int LEAD = 2;

  logic       clk_i = 0, rst_ni = 0;
  logic       tick_i = 1, osc_run_i = 0, bin_fmt_i = 1, hr24_i = 1, dst_en_i = 0;
  logic       inhibit_i = 0, wr_en_i = 0;
  logic [3:0] wr_addr_i = 0, rd_addr_i = 0;
  logic [7:0] wr_data_i = 0;
  logic [7:0] rd_data_o;
  logic       uip_o, upd_done_o, alarm_o;

  int n_chk = 0, n_fail = 0;
  int ms, mm, mh, mdw, mdt, mmo, myr;
  bit mfall = 0;
  int a_s = 0, a_m = 0, a_h = 0, a_d = 0;
  bit uip_seen;

  rtc_update_engine #(.TICKS_PER_SEC(TPS), .UIP_LEAD_TICKS(LEAD)) u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int enc(int v);
    return bin_fmt_i ? v : (v / 10) * 16 + v % 10;
  endfunction

  function automatic int enc_h(int h);
    int h12;
    if (hr24_i) return enc(h);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return (h >= 12 ? 128 : 0) + enc(h12);
  endfunction

  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic bit alarm_exp();
    return ((a_s & 8'hC0) == 8'hC0 || a_s == enc(ms)) &&
           ((a_m & 8'hC0) == 8'hC0 || a_m == enc(mm)) &&
           ((a_h & 8'hC0) == 8'hC0 || a_h == enc_h(mh)) &&
           (a_d == 0 || a_d == enc(mdt));
  endfunction

  task automatic model_step();
    bit at159 = (mh == 1 && mm == 59 && ms == 59);
    if (dst_en_i && at159 && mmo == 4 && mdw == 1 && mdt <= 7) begin
      mh = 3; mm = 0; ms = 0;
    end else if (dst_en_i && at159 && mmo == 10 && mdw == 1 && mdt >= 25 && !mfall) begin
      mh = 1; mm = 0; ms = 0; mfall = 1;
    end else begin
      if (mh == 23 && mm == 59 && ms == 59) mfall = 0;
      ms++;
      if (ms == 60) begin
        ms = 0; mm++;
        if (mm == 60) begin
          mm = 0; mh++;
          if (mh == 24) begin
            mh = 0; mdw = mdw % 7 + 1; mdt++;
            if (mdt > mdays(mmo, myr)) begin
              mdt = 1; mmo++;
              if (mmo == 13) begin mmo = 1; myr = (myr + 1) % 100; end
            end
          end
        end
      end
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en_i = 1; wr_addr_i = 4'(a); wr_data_i = 8'(d);
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr_i = 4'(a);
    #0.1;
    v = rd_data_o;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
      if (uip_o) uip_seen = 1;
    end while (!upd_done_o && n < 100);
  endtask

  // at a done cycle: step model, check alarm, then read published buffer
  task automatic after_done(input string tb, input string ta);
    logic [55:0] act, exp;
    int v;
    model_step();
    chk(alarm_o == alarm_exp(), ta, alarm_o, alarm_exp());
    @(negedge clk_i);
    act = 0; exp = 0;
    for (int i = 0; i < 7; i++) begin
      rd(i, v);
      act = {act[47:0], v[7:0]};
    end
    exp = {8'(enc(ms)), 8'(enc(mm)), 8'(enc_h(mh)), 8'(enc(mdw)),
           8'(enc(mdt)), 8'(enc(mmo)), 8'(enc(myr))};
    chk(act == exp, tb, act, exp);
  endtask

  task automatic sec_check(input string tb, input string ta);
    int n;
    wait_done(n);
    after_done(tb, ta);
  endtask

  task automatic set_time(input int s, m, h, dw, dt, mo, yr,
                          input string tb, input string ta);
    int n;
    @(negedge clk_i);
    osc_run_i = 0; inhibit_i = 1;
    @(negedge clk_i);
    chk(!uip_o && !upd_done_o, "R7", {uip_o, upd_done_o}, 0);
    ms = s; mm = m; mh = h; mdw = dw; mdt = dt; mmo = mo; myr = yr;
    wr(0, enc(s)); wr(1, enc(m)); wr(2, enc_h(h)); wr(3, enc(dw));
    wr(4, enc(dt)); wr(5, enc(mo)); wr(6, enc(yr));
    inhibit_i = 0;
    @(negedge clk_i);
    osc_run_i = 1;
    wait_done(n);
    chk(n == TPS / 2 + 1, "R7", n, TPS / 2 + 1);
    after_done(tb, ta);
  endtask

  task automatic set_alarm(input int s, m, h, d);
    a_s = s; a_m = m; a_h = h; a_d = d;
    wr(7, s); wr(8, m); wr(9, h); wr(10, d);
  endtask

  initial begin
    int v, n, u, old;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R12 reset state and address map
    rd(0, v); chk(v == 0, "R12", v, 0);
    chk(!uip_o && !upd_done_o && !alarm_o, "R12", {uip_o, upd_done_o, alarm_o}, 0);
    set_alarm(8'hC0, 8'hC0, 8'hC0, 0);
    wr(11, 8'h55);
    rd(11, v); chk(v == 0, "R12", v, 0);
    rd(9, v);  chk(v == 8'hC0, "R12", v, 8'hC0);

    // R4 leap-year crossing, binary 24h
    set_time(58, 59, 23, 4, 28, 2, 24, "R4", "R8");
    repeat (3) sec_check("R4", "R8");

    // R1 period and UIP window
    wait_done(n);
    model_step();
    n = 0; u = 0;
    do begin
      @(negedge clk_i);
      n++;
      if (uip_o) u++;
    end while (!upd_done_o && n < 100);
    chk(n == TPS, "R1", n, TPS);
    chk(u == LEAD + 2, "R1", u, LEAD + 2);
    after_done("R1", "R8");

    // R4 month-end sweep and leap cycle
    for (int mo = 1; mo <= 12; mo++)
      set_time(59, 59, 23, 3, mdays(mo, 23), mo, 23, "R4", "R8");
    for (int yr = 0; yr < 8; yr++)
      set_time(59, 59, 23, 2, 28, 2, yr, "R4", "R8");
    set_time(59, 59, 23, 7, 31, 12, 99, "R4", "R8");

    // R5/R6 BCD, 12-hour sweep over every hour
    bin_fmt_i = 0; hr24_i = 0;
    for (int h = 0; h < 24; h++)
      set_time(59, 59, h, 1, 15, 6, 45, "R6", "R8");
    hr24_i = 1;
    set_time(59, 59, 19, 5, 30, 9, 89, "R5", "R8");
    sec_check("R5", "R8");
    bin_fmt_i = 1;

    // R2 inhibit freezes buffer, time keeps counting
    set_time(10, 0, 8, 2, 10, 5, 30, "R4", "R8");
    inhibit_i = 1;
    rd(0, old);
    uip_seen = 0;
    for (int k = 0; k < 3; k++) begin
      wait_done(n);
      model_step();
    end
    @(negedge clk_i);
    rd(0, v);
    chk(v == old, "R2", v, old);
    chk(uip_seen == 0, "R2", uip_seen, 0);
    inhibit_i = 0;
    sec_check("R2", "R8");

    // R3 partial write loads only the written field
    inhibit_i = 1;
    wr(1, enc(30));
    inhibit_i = 0;
    mm = 30;
    sec_check("R3", "R8");
    sec_check("R3", "R8");

    // R8 alarm once per minute, full match, mismatching date
    set_alarm(5, 8'hC0, 8'hC0, 0);
    set_time(2, 10, 4, 3, 9, 7, 40, "R4", "R8");
    repeat (5) sec_check("R4", "R8");
    set_alarm(30, 20, 10, 15);
    set_time(28, 20, 10, 3, 15, 7, 40, "R4", "R9");
    repeat (3) sec_check("R4", "R9");
    set_alarm(30, 20, 10, 16);
    set_time(28, 20, 10, 3, 15, 7, 40, "R4", "R9");
    repeat (3) sec_check("R4", "R9");
    set_alarm(30, 20, 8'hC0, 0);
    set_time(29, 20, 17, 3, 3, 7, 40, "R4", "R9");
    sec_check("R4", "R9");
    set_alarm(8'hC0, 8'hC0, 8'hC0, 0);

    // R10/R11 daylight saving
    dst_en_i = 1;
    set_time(59, 59, 1, 1, 5, 4, 30, "R10", "R8");
    set_time(59, 59, 1, 1, 12, 4, 30, "R10", "R8");
    set_time(59, 59, 1, 1, 27, 10, 30, "R11", "R8");
    set_time(59, 59, 1, 1, 27, 10, 30, "R11", "R8");
    dst_en_i = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule